// File: doc/BRIEF.md
# Shift-Register FIFO with Single Tap Counter

This block is a synchronous first-in first-out buffer, sixteen words deep by default, built from one addressable shift register rather than from a memory with two pointers. A write always enters at stage 0 and moves every stored word one stage further along. A single up/down tap counter chooses which stage is shown on the read port. The counter rises on a write alone, falls on a read alone, and holds when both happen in the same cycle, so it always points at the oldest stored word. The read port is a combinational multiplexer on the counter. The oldest word is therefore visible without a read request (show-ahead), and it is valid only while the buffer is not empty.

With N words stored, the counter holds N-1. A counter cannot hold -1, so a small control state machine marks the zero-word case. It has three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are as follows. `ST_EMPTY` goes to `ST_PARTIAL` on an accepted write. `ST_PARTIAL` goes to `ST_FULL` on a write alone when the counter is at DEPTH-2. `ST_PARTIAL` goes to `ST_EMPTY` on a read alone when the counter is at 0. `ST_FULL` goes to `ST_PARTIAL` on a read alone. Every other input combination keeps the current state. Words that have been read stay in the register until later writes push them out, but the counter never selects them again. The design assumes DEPTH is at least 2.

Top module: `shreg_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, count is 0 and rd_data is 0 (all stages are cleared).
- R2: A write without a read, when the buffer is not full, raises count by one on the next clock. rd_data keeps showing the oldest word. Into an empty buffer, the written word appears on rd_data right after that clock edge.
- R3: A read without a write, when the buffer is not empty, lowers count by one on the next clock, and rd_data shows the next-oldest word.
- R4: A read and a write in the same cycle, when the buffer is not empty, leave count unchanged, and rd_data shows the next-oldest word.
- R5: Words leave in the order in which they were written. rd_data always equals the oldest accepted word that has not been read, and a word that has been read is never shown again.
- R6: full is 1 exactly when count equals DEPTH (16 by default). empty is 1 exactly when count is 0.
- R7: A write without a read while full is ignored. count stays at DEPTH, rd_data is unchanged, and the stored words drain in their original order.
- R8: A read while empty is ignored and count stays 0. If a write comes in the same cycle, that word is stored and count becomes 1.
- R9: A read and a write in the same cycle while full are both accepted. count stays at DEPTH and the order is preserved.
- R10: count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request; consumes the word shown on rd_data |
| rd_data | output | WIDTH | Oldest stored word, combinational from the tap counter |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |
| count | output | $clog2(DEPTH+1) | Number of stored words, 0 to DEPTH |

## Verification
The assertions assume that wr_en and rd_en are known (not X) at every rising edge after reset. They also assume that wr_data is stable around the edge on which a write is taken. The hold checks on rd_data depend on the request inputs not changing near the edge. The bench drives every input on the falling edge and samples every output on the following falling edge, so inputs never move close to the edge the design uses. Requests are always driven to a definite 0 or 1, including requests that the design must ignore.

// File: rtl/shreg_fifo_pkg.sv
package shreg_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

endpackage

// File: rtl/shreg_fifo_store.sv
module shreg_fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic [WIDTH-1:0]         din,
    output logic [DEPTH*WIDTH-1:0]   taps
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [WIDTH-1:0] stage_q;
        logic [WIDTH-1:0] stage_in;

        if (g == 0) begin : g_head
            assign stage_in = din;
        end else begin : g_body
            assign stage_in = taps[(g-1)*WIDTH +: WIDTH];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if (shift_en) begin
                stage_q <= stage_in;
            end
        end

        assign taps[g*WIDTH +: WIDTH] = stage_q;
    end

endmodule

// File: rtl/shreg_fifo_tapsel.sv
module shreg_fifo_tapsel #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH*WIDTH-1:0] taps,
    input  logic [PTR_W-1:0]       sel,
    output logic [WIDTH-1:0]       dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == PTR_W'(i)) begin
                dout = taps[i*WIDTH +: WIDTH];
            end
        end
    end

endmodule

// File: rtl/shreg_fifo_ctrl.sv
module shreg_fifo_ctrl
    import shreg_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             shift_en,
    output logic [PTR_W-1:0] tap_ptr,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] PTR_NEAR_TOP = PTR_W'(DEPTH - 2);

    fill_state_e state_q, state_d;
    logic        push, pop;
    logic        push_only, pop_only;

    assign push      = wr_en && ((state_q != ST_FULL) || rd_en);
    assign pop       = rd_en && (state_q != ST_EMPTY);
    assign push_only = push && !pop;
    assign pop_only  = pop && !push;
    assign shift_en  = push;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push_only && tap_ptr == PTR_NEAR_TOP) begin
                    state_d = ST_FULL;
                end else if (pop_only && tap_ptr == '0) begin
                    state_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (pop_only) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_ptr <= '0;
        end else if (push_only && state_q != ST_EMPTY) begin
            tap_ptr <= tap_ptr + PTR_W'(1);
        end else if (pop_only && tap_ptr != '0) begin
            tap_ptr <= tap_ptr - PTR_W'(1);
        end
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        count = CNT_W'(tap_ptr) + CNT_W'(1);
        unique case (state_q)
            ST_EMPTY: begin
                empty = 1'b1;
                count = '0;
            end
            ST_PARTIAL: begin
            end
            ST_FULL: begin
                full = 1'b1;
            end
            default: begin
                empty = 1'b1;
                count = '0;
            end
        endcase
    end

endmodule

// File: rtl/shreg_fifo.sv
module shreg_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic                   shift_en;
    logic [PTR_W-1:0]       tap_ptr;
    logic [DEPTH*WIDTH-1:0] taps;

    shreg_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .shift_en (shift_en),
        .tap_ptr  (tap_ptr),
        .empty    (empty),
        .full     (full),
        .count    (count)
    );

    shreg_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (wr_data),
        .taps     (taps)
    );

    shreg_fifo_tapsel #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tapsel (
        .taps (taps),
        .sel  (tap_ptr),
        .dout (rd_data)
    );

endmodule

// File: rtl/shreg_fifo_chk.sv
module shreg_fifo_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] count
);

    // R6
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (count == CNT_W'(DEPTH)));

    // R6
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count == '0));

    // R2
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !full) |=> (count == $past(count) + CNT_W'(1)));

    // R2
    oldest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !full && !empty) |=> $stable(rd_data));

    // R3
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !empty) |=> (count == $past(count) - CNT_W'(1)));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && !empty) |=> $stable(count));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && full) |=> (full && $stable(rd_data)));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && empty) |=> empty);

    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

bind shreg_fifo shreg_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .count   (count)
);

// File: tb/test_shreg_fifo.sv
module test_shreg_fifo;

    localparam int WIDTH = 8;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             full, empty;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int fails  = 0;
    logic [WIDTH-1:0] model_q[$];

    always #10 clk = ~clk;

    shreg_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_shreg_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .full    (full),
        .empty   (empty),
        .count   (count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int n = model_q.size();
        check({tag, " count"}, int'(count), n);
        check("R6 full", int'(full), int'(n == DEPTH));
        check("R6 empty", int'(empty), int'(n == 0));
        check("R10 count range", int'(count <= CNT_W'(DEPTH)), 1);
        if (n > 0) check({"R5 ", tag, " rd_data"}, int'(rd_data), int'(model_q[0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_q.delete();
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 count", int'(count), 0);
        check("R1 rd_data", int'(rd_data), 0);
    endtask

    // one clocked operation; inputs set on the falling edge, outputs sampled one falling edge later
    task automatic op(input logic w, input logic r, input logic [WIDTH-1:0] d);
        string tag;
        int n = model_q.size();
        logic push, pop;
        wr_en = w; rd_en = r; wr_data = d;
        push = w && (n < DEPTH || r);
        pop  = r && (n > 0);
        if (w && r)       tag = (n == DEPTH) ? "R9" : (n == 0 ? "R8" : "R4");
        else if (w)       tag = (n == DEPTH) ? "R7" : "R2";
        else if (r)       tag = (n == 0) ? "R8" : "R3";
        else              tag = "idle";
        @(negedge clk);
        if (pop)  void'(model_q.pop_front());
        if (push) model_q.push_back(d);
        compare_all(tag);
    endtask

    initial begin
        int seed_word = 1;
        do_reset();

        // R2: first write into empty shows the word right after the edge
        op(1'b1, 1'b0, 8'hA5);
        check("R2 show-ahead", int'(rd_data), 8'hA5);

        // sweep: from every fill level, try every request combination, then drain
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int mode = 0; mode < 4; mode++) begin
                do_reset();
                for (int k = 0; k < lvl; k++) begin
                    op(1'b1, 1'b0, WIDTH'(seed_word));
                    seed_word = seed_word * 7 + 3;
                end
                op(mode[0], mode[1], 8'hEE);
                while (model_q.size() > 0) op(1'b0, 1'b1, '0);
                op(1'b0, 1'b1, '0);
            end
        end

        // R7: fill, push extra words while full, drain in original order
        do_reset();
        for (int k = 0; k < DEPTH; k++) op(1'b1, 1'b0, WIDTH'(k + 16));
        for (int k = 0; k < 3; k++) op(1'b1, 1'b0, 8'hFF);
        for (int k = 0; k < DEPTH; k++) begin
            check("R7 drain order", int'(rd_data), k + 16);
            op(1'b0, 1'b1, '0);
        end

        // R9: steady read+write while full keeps order
        do_reset();
        for (int k = 0; k < DEPTH; k++) op(1'b1, 1'b0, WIDTH'(k));
        for (int k = 0; k < 40; k++) op(1'b1, 1'b1, WIDTH'(100 + k));

        // randomized mix against the queue model
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] pick = 4'($urandom);
            op(pick < 4'd9, pick > 4'd5, WIDTH'($urandom));
        end

        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule